// File: doc/BRIEF.md
# Two-Level Page Walk Engine

This block turns a 32-bit virtual address into a physical address by walking a two-level translation structure in memory. A context register names the 4 KiB frame of the top-level directory. Each directory slot points at a 4 KiB table, and each table slot points at a 4 KiB physical frame. The upper ten address bits select the directory slot, the next ten select the table slot, and the low twelve bits pass straight through as the page offset.

A request carries the virtual address, a write flag and a user flag. The engine takes one request at a time. It reads each entry through a single-outstanding word port and checks that the entry is present. It then checks user and write permission over both levels. It sets the accessed flag and, on writes, the dirty flag, writing an entry back only when one of its flags changes. The response holds either the physical address or a fault with a three-bit cause, and it always carries the virtual address of the request. Software keeps the entries up to date and clears the status flags when it needs to.

Top module: `xlat_walker`

## Requirements
- R1: The directory slot is read from address {ctx_frame, vaddr[31:22], 2'b00}.
- R2: The table slot is read from address {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R3: A successful walk returns rsp_paddr = {table_entry[31:12], vaddr[11:0]} with rsp_fault low.
- R4: If directory entry bit 0 (present) is clear, the walk faults after that single read. No table read and no write take place.
- R5: If table entry bit 0 (present) is clear, the walk faults and rsp_cause bit 0 is 0.
- R6: When the walk uses a directory entry whose bit 5 (accessed) is clear, it writes the entry back with bit 5 set. If bit 5 is already set, the directory entry is not written.
- R7: On success the table entry gets bit 5 (accessed) set, plus bit 6 (dirty) on a write. It is written back only if that changes its value.
- R8: A user access faults unless bit 2 (user) is set in both entries. This is a protection fault: rsp_cause bit 0 is 1.
- R9: A user write also faults unless bit 1 (read/write) is set in both entries. A supervisor access never raises a protection fault.
- R10: rsp_cause bit 1 repeats the write flag and bit 2 repeats the user flag of the request. rsp_vaddr returns the request address.
- R11: req_ready is high only while idle. mem_req and its address and data stay stable until mem_ready. The response stays stable until rsp_ready.
- R12: On a table-level protection fault the table entry is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_frame | input | 20 | Frame number of the directory, sampled at request acceptance |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_fault | output | 1 | Walk faulted |
| rsp_cause | output | 3 | Fault cause: bit0 protection, bit1 write, bit2 user |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_vaddr | output | 32 | Virtual address of the request |
| mem_req | output | 1 | Memory access request |
| mem_ready | input | 1 | Access completes this cycle |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while mem_ready is high on a read |

## Verification
The assertions rely on a memory port that completes an access only in a cycle where mem_ready is high and mem_req is asserted. Read data must be valid in that same cycle. They also rely on rsp_ready being raised only while a response is pending. The bench's memory model drives mem_ready from a stall pattern gated by mem_req and returns data combinationally. Entries are loaded only while the engine is idle. The bench issues each request only after the previous response has been consumed.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int XW_AW   = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int FRM_W   = XW_AW - OFF_W;
  localparam int CAUSE_W = 3;

  localparam int F_PRES = 0;
  localparam int F_RW   = 1;
  localparam int F_USR  = 2;
  localparam int F_ACC  = 5;
  localparam int F_DRT  = 6;

  localparam int C_PROT = 0;
  localparam int C_WR   = 1;
  localparam int C_USR  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_DIR_EVAL, ST_DIR_WB,
    ST_TBL_RD, ST_TBL_EVAL, ST_TBL_WB, ST_RESP
  } walk_st_t;

  function automatic logic [IDX_W-1:0] dir_idx(input logic [XW_AW-1:0] va);
    return va[XW_AW-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] tbl_idx(input logic [XW_AW-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [OFF_W-1:0] page_off(input logic [XW_AW-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  // frame base + index*4 on a page-aligned frame is a plain concatenation
  function automatic logic [XW_AW-1:0] slot_addr(input logic [FRM_W-1:0] frame,
                                                  input logic [IDX_W-1:0] idx);
    return {frame, idx, 2'b00};
  endfunction

  function automatic logic [XW_AW-1:0] join_pa(input logic [FRM_W-1:0] frame,
                                                input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
  import xw_pkg::*;
(
  input  logic [FRM_W-1:0] ctx_frame,
  input  logic [XW_AW-1:0] vaddr,
  input  logic [FRM_W-1:0] dir_frame,
  input  logic [FRM_W-1:0] pg_frame,
  output logic [XW_AW-1:0] dir_slot,
  output logic [XW_AW-1:0] tbl_slot,
  output logic [XW_AW-1:0] phys
);
  always_comb begin
    dir_slot = slot_addr(ctx_frame, dir_idx(vaddr));
    tbl_slot = slot_addr(dir_frame, tbl_idx(vaddr));
    phys     = join_pa(pg_frame, page_off(vaddr));
  end
endmodule

// File: rtl/xw_perm_chk.sv
module xw_perm_chk (
  input  logic dir_rw,
  input  logic dir_usr,
  input  logic tbl_rw,
  input  logic tbl_usr,
  input  logic is_write,
  input  logic is_user,
  output logic violation
);
  logic usr_ok, wr_ok;
  always_comb begin
    usr_ok    = dir_usr & tbl_usr;
    wr_ok     = ~is_write | (dir_rw & tbl_rw);
    violation = is_user & ~(usr_ok & wr_ok);
  end
endmodule

// File: rtl/xw_entry_upd.sv
module xw_entry_upd
  import xw_pkg::*;
(
  input  logic [XW_AW-1:0] entry,
  input  logic             want_dirty,
  output logic [XW_AW-1:0] upd,
  output logic             need_wb
);
  always_comb begin
    upd         = entry;
    upd[F_ACC]  = 1'b1;
    if (want_dirty) upd[F_DRT] = 1'b1;
    need_wb     = (upd != entry);
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FRM_W-1:0]    ctx_frame,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [XW_AW-1:0]    req_vaddr,
  input  logic                req_write,
  input  logic                req_user,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_fault,
  output logic [CAUSE_W-1:0]  rsp_cause,
  output logic [XW_AW-1:0]    rsp_paddr,
  output logic [XW_AW-1:0]    rsp_vaddr,
  output logic                mem_req,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [XW_AW-1:0]    mem_addr,
  output logic [XW_AW-1:0]    mem_wdata,
  input  logic [XW_AW-1:0]    mem_rdata
);
  walk_st_t             st_q, st_d;
  logic [FRM_W-1:0]     ctx_q;
  logic [XW_AW-1:0]     va_q, dir_q, tbl_q;
  logic                 wr_q, usr_q;
  logic                 fault_q;
  logic [CAUSE_W-1:0]   cause_q;

  logic [XW_AW-1:0]     dir_slot, tbl_slot, phys;
  logic [XW_AW-1:0]     dir_upd, tbl_upd;
  logic                 dir_need_wb, tbl_need_wb;
  logic                 prot_viol;

  // named internal events
  logic ev_accept, ev_mem_done, ev_dir_absent, ev_tbl_absent, ev_prot, ev_walk_ok;

  xw_addr_gen u_addr (
    .ctx_frame (ctx_q),
    .vaddr     (va_q),
    .dir_frame (dir_q[XW_AW-1:OFF_W]),
    .pg_frame  (tbl_q[XW_AW-1:OFF_W]),
    .dir_slot  (dir_slot),
    .tbl_slot  (tbl_slot),
    .phys      (phys)
  );

  xw_perm_chk u_perm (
    .dir_rw    (dir_q[F_RW]),
    .dir_usr   (dir_q[F_USR]),
    .tbl_rw    (tbl_q[F_RW]),
    .tbl_usr   (tbl_q[F_USR]),
    .is_write  (wr_q),
    .is_user   (usr_q),
    .violation (prot_viol)
  );

  xw_entry_upd u_dir_upd (
    .entry      (dir_q),
    .want_dirty (1'b0),
    .upd        (dir_upd),
    .need_wb    (dir_need_wb)
  );

  xw_entry_upd u_tbl_upd (
    .entry      (tbl_q),
    .want_dirty (wr_q),
    .upd        (tbl_upd),
    .need_wb    (tbl_need_wb)
  );

  assign ev_accept     = (st_q == ST_IDLE) && req_valid;
  assign ev_mem_done   = mem_req && mem_ready;
  assign ev_dir_absent = (st_q == ST_DIR_EVAL) && !dir_q[F_PRES];
  assign ev_tbl_absent = (st_q == ST_TBL_EVAL) && !tbl_q[F_PRES];
  assign ev_prot       = (st_q == ST_TBL_EVAL) && tbl_q[F_PRES] && prot_viol;
  assign ev_walk_ok    = ((st_q == ST_TBL_EVAL) && tbl_q[F_PRES] && !prot_viol && !tbl_need_wb)
                      || ((st_q == ST_TBL_WB) && mem_ready);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (req_valid) st_d = ST_DIR_RD;
      ST_DIR_RD:   if (mem_ready) st_d = ST_DIR_EVAL;
      ST_DIR_EVAL: if (!dir_q[F_PRES]) st_d = ST_RESP;
                   else if (dir_need_wb) st_d = ST_DIR_WB;
                   else st_d = ST_TBL_RD;
      ST_DIR_WB:   if (mem_ready) st_d = ST_TBL_RD;
      ST_TBL_RD:   if (mem_ready) st_d = ST_TBL_EVAL;
      ST_TBL_EVAL: if (!tbl_q[F_PRES] || prot_viol) st_d = ST_RESP;
                   else if (tbl_need_wb) st_d = ST_TBL_WB;
                   else st_d = ST_RESP;
      ST_TBL_WB:   if (mem_ready) st_d = ST_RESP;
      ST_RESP:     if (rsp_ready) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ctx_q   <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      dir_q   <= '0;
      tbl_q   <= '0;
      fault_q <= 1'b0;
      cause_q <= '0;
    end else begin
      st_q <= st_d;
      if (ev_accept) begin
        ctx_q   <= ctx_frame;
        va_q    <= req_vaddr;
        wr_q    <= req_write;
        usr_q   <= req_user;
        fault_q <= 1'b0;
        cause_q <= '0;
      end
      if (st_q == ST_DIR_RD && mem_ready) dir_q <= mem_rdata;
      if (st_q == ST_DIR_WB && mem_ready) dir_q <= dir_upd;
      if (st_q == ST_TBL_RD && mem_ready) tbl_q <= mem_rdata;
      if (st_q == ST_TBL_WB && mem_ready) tbl_q <= tbl_upd;
      if (ev_dir_absent || ev_tbl_absent || ev_prot) begin
        fault_q         <= 1'b1;
        cause_q[C_PROT] <= ev_prot;
        cause_q[C_WR]   <= wr_q;
        cause_q[C_USR]  <= usr_q;
      end
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      ST_DIR_RD: begin mem_req = 1'b1; mem_addr = dir_slot; end
      ST_DIR_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dir_slot; mem_wdata = dir_upd; end
      ST_TBL_RD: begin mem_req = 1'b1; mem_addr = tbl_slot; end
      ST_TBL_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = tbl_slot; mem_wdata = tbl_upd; end
      default: ;
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_fault = fault_q;
  assign rsp_cause = cause_q;
  assign rsp_paddr = fault_q ? '0 : phys;
  assign rsp_vaddr = va_q;

  // ---------------- assertions ----------------
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req));                                   // R11
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause) && $stable(rsp_fault))); // R11
  AST_WB_HAS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[F_ACC]);                                  // R6
  AST_DIRTY_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TBL_WB && wr_q) |-> mem_wdata[F_DRT]);                          // R7
  AST_DIR_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_absent |=> (!mem_req && rsp_valid && rsp_fault));                    // R4
  AST_SUPER_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !rsp_cause[C_USR]) |-> !rsp_cause[C_PROT]);      // R9
  AST_CAUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_cause[C_WR] == wr_q && rsp_cause[C_USR] == usr_q)); // R10
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0])); // R3
  AST_PROT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prot |=> !mem_req);                                                      // R12
  AST_OK_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_walk_ok |=> (rsp_valid && !rsp_fault));                                  // R3
endmodule

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] ctx_frame = 20'h00001;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic        rsp_ready = 1'b0;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_paddr, rsp_vaddr;
  logic        mem_req, mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:4095];
  int          n_chk = 0, n_bad = 0, n_wr = 0, n_rd = 0, cyc = 0;
  logic        stall = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  xlat_walker u_dut (
    .clk(clk), .rst_n(rst_n), .ctx_frame(ctx_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_ready = mem_req && !stall;
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(negedge clk) begin
    cyc   <= cyc + 1;
    stall <= (cyc % 3) == 1;
  end

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin mem[mem_addr[13:2]] <= mem_wdata; n_wr <= n_wr + 1; end
      else n_rd <= n_rd + 1;
    end
  end

  localparam logic [31:0] P = 32'h01, RW = 32'h02, U = 32'h04, A = 32'h20, D = 32'h40;

  function automatic logic [31:0] ent(input logic [19:0] fr, input logic [31:0] fl);
    return {fr, 12'h000} | fl;
  endfunction
  function automatic logic [31:0] va(input int di, input int ti, input int off);
    return (32'(di) << 22) | (32'(ti) << 12) | 32'(off & 12'hfff);
  endfunction
  function automatic int slot(input logic [19:0] fr, input int idx);
    return ((32'(fr) << 12) + idx * 4) >> 2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        r_f;
  logic [2:0]  r_c;
  logic [31:0] r_pa, r_va;
  int          d_wr, d_rd;

  task automatic xlate(input logic [31:0] v, input bit w, input bit u, input int hold);
    int w0, r0;
    @(negedge clk);
    w0 = n_wr; r0 = n_rd;
    req_vaddr = v; req_write = w; req_user = u; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_f = rsp_fault; r_c = rsp_cause; r_pa = rsp_paddr; r_va = rsp_vaddr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R11 rsp held valid", 32'(rsp_valid), 32'd1);
      chk("R11 rsp paddr stable", rsp_paddr, r_pa);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    d_wr = n_wr - w0; d_rd = n_rd - r0;
  endtask

  task automatic t_reset();
    chk("R11 reset req_ready", 32'(req_ready), 32'd1);
    chk("R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11 reset mem_req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_basic_read();
    logic [31:0] v = va(1, 5, 12'h123);
    xlate(v, 0, 0, 0);
    chk("R3 ok no fault", 32'(r_f), 32'd0);
    chk("R1 R2 R3 paddr", r_pa, 32'hABCDE123);
    chk("R6 R7 two writebacks", 32'(d_wr), 32'd2);
    chk("R6 dir accessed set", mem[slot(20'h1, 1)], ent(20'h2, P | RW | U | A));
    chk("R7 tbl accessed no dirty", mem[slot(20'h2, 5)], ent(20'hABCDE, P | A));
    chk("R10 vaddr echo", r_va, v);
  endtask

  task automatic t_repeat_read();
    xlate(va(1, 5, 12'hfff), 0, 0, 0);
    chk("R3 repeat paddr", r_pa, 32'hABCDEFFF);
    chk("R6 R7 no writes when flags set", 32'(d_wr), 32'd0);
  endtask

  task automatic t_super_write();
    xlate(va(1, 5, 12'h004), 1, 0, 0);
    chk("R9 supervisor write ignores rw", 32'(r_f), 32'd0);
    chk("R7 dirty written", mem[slot(20'h2, 5)], ent(20'hABCDE, P | A | D));
    chk("R7 one writeback", 32'(d_wr), 32'd1);
  endtask

  task automatic t_dir_absent();
    logic [31:0] v = va(3, 1, 12'h010);
    xlate(v, 1, 1, 0);
    chk("R4 fault", 32'(r_f), 32'd1);
    chk("R4 R10 cause", 32'(r_c), 32'b110);
    chk("R4 single read", 32'(d_rd), 32'd1);
    chk("R4 no writes", 32'(d_wr), 32'd0);
    chk("R10 fault vaddr", r_va, v);
    chk("R4 zero paddr", r_pa, 32'd0);
  endtask

  task automatic t_tbl_absent();
    xlate(va(1, 6, 12'h000), 0, 0, 0);
    chk("R5 fault", 32'(r_f), 32'd1);
    chk("R5 cause", 32'(r_c), 32'b000);
    chk("R2 R5 two reads", 32'(d_rd), 32'd2);
  endtask

  task automatic t_user_no_dir_u();
    xlate(va(4, 7, 12'h020), 0, 1, 0);
    chk("R8 fault", 32'(r_f), 32'd1);
    chk("R8 cause", 32'(r_c), 32'b101);
    chk("R6 dir wb only", 32'(d_wr), 32'd1);
    chk("R12 tbl untouched", mem[slot(20'h3, 7)], ent(20'h11111, P | RW | U));
  endtask

  task automatic t_user_write_ro();
    xlate(va(2, 9, 12'h030), 1, 1, 0);
    chk("R9 fault", 32'(r_f), 32'd1);
    chk("R9 cause", 32'(r_c), 32'b111);
    chk("R12 no writes", 32'(d_wr), 32'd0);
    chk("R12 tbl untouched", mem[slot(20'h3, 9)], ent(20'h33333, P | U | A));
  endtask

  task automatic t_user_write_ok();
    xlate(va(2, 10, 12'h7a8), 1, 1, 0);
    chk("R8 R9 allowed", 32'(r_f), 32'd0);
    chk("R3 paddr", r_pa, 32'h222227A8);
    chk("R7 acc+dirty", mem[slot(20'h3, 10)], ent(20'h22222, P | RW | U | A | D));
  endtask

  task automatic t_rsp_hold();
    xlate(va(2, 10, 12'h001), 0, 1, 5);
    chk("R11 held result", r_pa, 32'h22222001);
    chk("R11 released", 32'(rsp_valid), 32'd0);
    chk("R11 ready again", 32'(req_ready), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[slot(20'h1, 1)]  = ent(20'h2, P | RW | U);
    mem[slot(20'h1, 2)]  = ent(20'h3, P | RW | U | A);
    mem[slot(20'h1, 4)]  = ent(20'h3, P | RW);
    mem[slot(20'h2, 5)]  = ent(20'hABCDE, P);
    mem[slot(20'h3, 7)]  = ent(20'h11111, P | RW | U);
    mem[slot(20'h3, 9)]  = ent(20'h33333, P | U | A);
    mem[slot(20'h3, 10)] = ent(20'h22222, P | RW | U);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_read();
    t_repeat_read();
    t_super_write();
    t_dir_absent();
    t_tbl_absent();
    t_user_no_dir_u();
    t_user_write_ro();
    t_user_write_ok();
    t_rsp_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule